// File: doc/BRIEF.md
# Circular and Bit-Reverse Address Generator

This block produces data-memory addresses for a signal-processing core. Each generator keeps four banks of registers: index pointers, step values, buffer lengths and buffer bases. On every cycle it can turn one access request into an effective address. The address comes from an index register, optionally offset by a step. The step is either a stored step register or an immediate operand carried with the request. The pointer update can wrap inside a circular buffer of any length, starting at any address. The low address bits can also be mirrored to walk an FFT array in scrambled order.

The top holds several independent generators, two by default. This lets two memory paths each receive an address in the same clock cycle. The register banks load through a simple write port per generator. Each access takes one request cycle. Its address and the resulting pointer value appear on registered outputs on the next cycle. A new request can be accepted every cycle.

Top module: `dual_dag`

## Requirements
- R1: Reset (synchronous, active high) clears every index, step, length and base register of every generator. It also drives `ea`, `idx_out` and `ea_vld` to zero.
- R2: Post-modify (`op_mode` bit 0 = 0) works in two parts.
  - The address is the selected index register.
  - The register then takes its stepped value.
  - Both `ea` and `idx_out` (the new pointer) are valid on the cycle after the request, with `ea_vld` high.
- R3: Pre-modify (`op_mode` bit 0 = 1) outputs index + step without circular wrap. It leaves the index register unchanged, and `idx_out` reports that unchanged value.
- R4: `op_mode` bit 1 chooses the step source. 0 means the step register selected by `op_mreg`. 1 means the two's-complement immediate `op_imm`.
- R5: With a non-zero length L, base B and a non-negative step, a post-modify wraps the pointer when I+step ≥ B+L. The new pointer is then I+step−L. B need not be a power-of-two multiple, and a step equal to L is allowed.
- R6: With a non-zero length and a negative step, a post-modify wraps the pointer when I+step < B. The new pointer is then I+step+L.
- R7: A length register of zero makes the pointer update linear, I+step, with no wrap.
- R8: `op_brn` = N mirrors the low N bits of the address on `ea` (bit k takes bit N−1−k) and leaves the upper bits alone. N = 0 changes nothing. Values up to the address width are honoured. The mirror does not alter the pointer update.
- R9: Generators share no state. Requests on all generators in the same cycle each produce their own correct address.
- R10: The write port codes `wr_kind` as 0 index, 1 step, 2 length and 3 base, with `wr_idx` selecting the register. If a write and a post-modify update target the same index register in one cycle, the written value is kept.
- R11: One request is accepted per cycle. `ea_vld` on a cycle equals `op_en` on the cycle before. Without a request, `ea` and `idx_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_en | input | NGEN | Access request per generator |
| op_ireg | input | NGEN×3 | Index register select |
| op_mreg | input | NGEN×3 | Step register select |
| op_mode | input | NGEN×2 | Bit 0: pre-modify; bit 1: immediate step |
| op_imm | input | NGEN×32 | Immediate step (two's complement) |
| op_brn | input | NGEN×6 | Count of low address bits to mirror |
| wr_en | input | NGEN | Register write strobe |
| wr_kind | input | NGEN×2 | Register bank: 0 index, 1 step, 2 length, 3 base |
| wr_idx | input | NGEN×3 | Register number within the bank |
| wr_data | input | NGEN×32 | Write value |
| ea | output | NGEN×32 | Effective address, one cycle after request |
| idx_out | output | NGEN×32 | Index register value after the access |
| ea_vld | output | NGEN | Address valid |

## Verification
The assertions watch several things on every cycle.
- The valid flag follows the request one cycle later, and both result ports hold while idle.
- Two back-to-back post-modify accesses to the same pointer chain: the second address equals the pointer reported by the first.
- A pre-modify access leaves the reported pointer unchanged.
- Reset clears the outputs.

The actual arithmetic needs the bench's scenarios, because the register contents are only visible through accesses. This covers circular wrap at both ends of an unaligned buffer, a step equal to the length, linear stepping with zero length, mirroring for several field widths, simultaneous requests on both generators, and a write colliding with an update.

// File: rtl/dag_pkg.sv
package dag_pkg;

    localparam int DEF_AW   = 32;
    localparam int DEF_NREG = 8;
    localparam int DEF_NGEN = 2;

    // Register bank selector used by the write port (R10 encoding)
    typedef enum logic [1:0] {
        KIND_IDX  = 2'd0,
        KIND_STEP = 2'd1,
        KIND_LEN  = 2'd2,
        KIND_BASE = 2'd3
    } reg_kind_e;

    // Access mode: bit 0 pre-modify, bit 1 immediate step (R2, R3, R4)
    typedef enum logic [1:0] {
        MODE_POST_REG = 2'b00,
        MODE_PRE_REG  = 2'b01,
        MODE_POST_IMM = 2'b10,
        MODE_PRE_IMM  = 2'b11
    } mode_e;

    function automatic logic mode_is_pre(mode_e m);
        return (m == MODE_PRE_REG) || (m == MODE_PRE_IMM);
    endfunction

    function automatic logic mode_uses_imm(mode_e m);
        return (m == MODE_POST_IMM) || (m == MODE_PRE_IMM);
    endfunction

endpackage

// File: rtl/dag_bitrev.sv
// Mirrors the low n bits of an address (R8)
module dag_bitrev #(
    parameter int AW = 32,
    localparam int NW = $clog2(AW + 1)
) (
    input  logic [AW-1:0] a,
    input  logic [NW-1:0] n,
    output logic [AW-1:0] y
);

    logic [AW-1:0] rev;
    logic [AW-1:0] mask;
    int            nn;

    for (genvar k = 0; k < AW; k++) begin : g_rev
        assign rev[k] = a[AW-1-k];
    end

    always_comb begin
        nn   = (int'(n) > AW) ? AW : int'(n);
        mask = ~({AW{1'b1}} << nn);
        y    = (a & ~mask) | ((rev >> (AW - nn)) & mask);
    end

endmodule

// File: rtl/dag_modulo.sv
// Stepped pointer with circular wrap (R5, R6, R7)
module dag_modulo #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] idx,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] len,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] nxt
);

    logic [AW:0] sum;
    logic [AW:0] lim;
    logic        neg;
    logic        over;
    logic        under;

    always_comb begin
        neg   = step[AW-1];
        sum   = {1'b0, idx} + {step[AW-1], step};
        lim   = {1'b0, base} + {1'b0, len};
        over  = !neg && (sum >= lim);
        under = neg && (sum[AW] || (sum[AW-1:0] < base));
        if (len == '0)
            nxt = sum[AW-1:0];
        else if (over)
            nxt = sum[AW-1:0] - len;
        else if (under)
            nxt = sum[AW-1:0] + len;
        else
            nxt = sum[AW-1:0];
    end

endmodule

// File: rtl/dag_regbank.sv
// Index / step / length / base registers of one generator
module dag_regbank
    import dag_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREG = 8,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  reg_kind_e     wr_kind,
    input  logic [SW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic          upd_en,
    input  logic [SW-1:0] upd_idx,
    input  logic [AW-1:0] upd_data,
    input  logic [SW-1:0] rd_isel,
    input  logic [SW-1:0] rd_msel,
    output logic [AW-1:0] rd_i,
    output logic [AW-1:0] rd_m,
    output logic [AW-1:0] rd_l,
    output logic [AW-1:0] rd_b
);

    logic [AW-1:0] i_q [NREG];
    logic [AW-1:0] m_q [NREG];
    logic [AW-1:0] l_q [NREG];
    logic [AW-1:0] b_q [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NREG; k++) begin
                i_q[k] <= '0;
                m_q[k] <= '0;
                l_q[k] <= '0;
                b_q[k] <= '0;
            end
        end else begin
            if (upd_en)
                i_q[upd_idx] <= upd_data;
            // later assignment: a write beats a same-cycle update (R10)
            if (wr_en) begin
                unique case (wr_kind)
                    KIND_IDX:  i_q[wr_idx] <= wr_data;
                    KIND_STEP: m_q[wr_idx] <= wr_data;
                    KIND_LEN:  l_q[wr_idx] <= wr_data;
                    KIND_BASE: b_q[wr_idx] <= wr_data;
                endcase
            end
        end
    end

    assign rd_i = i_q[rd_isel];
    assign rd_m = m_q[rd_msel];
    assign rd_l = l_q[rd_isel];
    assign rd_b = b_q[rd_isel];

endmodule

// File: rtl/dag_unit.sv
// One address generator: operand select, wrap, mirror, output register
module dag_unit
    import dag_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREG = 8,
    localparam int SW  = $clog2(NREG),
    localparam int NW  = $clog2(AW + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_en,
    input  logic [SW-1:0] op_ireg,
    input  logic [SW-1:0] op_mreg,
    input  mode_e         op_mode,
    input  logic [AW-1:0] op_imm,
    input  logic [NW-1:0] op_brn,
    input  logic          wr_en,
    input  reg_kind_e     wr_kind,
    input  logic [SW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] idx_out,
    output logic          ea_vld
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] ptr;
    } result_t;

    logic [AW-1:0] rd_i, rd_m, rd_l, rd_b;
    logic [AW-1:0] step, wrapped, raw, mapped;
    logic          pre;
    result_t       res_d, res_q;
    logic          vld_q;

    dag_regbank #(.AW(AW), .NREG(NREG)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_kind  (wr_kind),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .upd_en   (op_en && !pre),
        .upd_idx  (op_ireg),
        .upd_data (wrapped),
        .rd_isel  (op_ireg),
        .rd_msel  (op_mreg),
        .rd_i     (rd_i),
        .rd_m     (rd_m),
        .rd_l     (rd_l),
        .rd_b     (rd_b)
    );

    dag_modulo #(.AW(AW)) u_wrap (
        .idx  (rd_i),
        .step (step),
        .len  (rd_l),
        .base (rd_b),
        .nxt  (wrapped)
    );

    dag_bitrev #(.AW(AW)) u_rev (
        .a (raw),
        .n (op_brn),
        .y (mapped)
    );

    always_comb begin
        pre        = mode_is_pre(op_mode);
        step       = mode_uses_imm(op_mode) ? op_imm : rd_m;
        raw        = pre ? (rd_i + step) : rd_i;
        res_d.addr = mapped;
        res_d.ptr  = pre ? rd_i : wrapped;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= op_en;
            if (op_en)
                res_q <= res_d;
        end
    end

    assign ea      = res_q.addr;
    assign idx_out = res_q.ptr;
    assign ea_vld  = vld_q;

endmodule

// File: rtl/dual_dag.sv
// Top: NGEN independent address generators (R9)
module dual_dag
    import dag_pkg::*;
#(
    parameter int AW   = DEF_AW,
    parameter int NREG = DEF_NREG,
    parameter int NGEN = DEF_NGEN,
    localparam int SW  = $clog2(NREG),
    localparam int NW  = $clog2(AW + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NGEN-1:0]           op_en,
    input  logic [NGEN-1:0][SW-1:0]   op_ireg,
    input  logic [NGEN-1:0][SW-1:0]   op_mreg,
    input  logic [NGEN-1:0][1:0]      op_mode,
    input  logic [NGEN-1:0][AW-1:0]   op_imm,
    input  logic [NGEN-1:0][NW-1:0]   op_brn,
    input  logic [NGEN-1:0]           wr_en,
    input  logic [NGEN-1:0][1:0]      wr_kind,
    input  logic [NGEN-1:0][SW-1:0]   wr_idx,
    input  logic [NGEN-1:0][AW-1:0]   wr_data,
    output logic [NGEN-1:0][AW-1:0]   ea,
    output logic [NGEN-1:0][AW-1:0]   idx_out,
    output logic [NGEN-1:0]           ea_vld
);

    for (genvar g = 0; g < NGEN; g++) begin : g_gen
        dag_unit #(.AW(AW), .NREG(NREG)) u_gen (
            .clk     (clk),
            .rst     (rst),
            .op_en   (op_en[g]),
            .op_ireg (op_ireg[g]),
            .op_mreg (op_mreg[g]),
            .op_mode (mode_e'(op_mode[g])),
            .op_imm  (op_imm[g]),
            .op_brn  (op_brn[g]),
            .wr_en   (wr_en[g]),
            .wr_kind (reg_kind_e'(wr_kind[g])),
            .wr_idx  (wr_idx[g]),
            .wr_data (wr_data[g]),
            .ea      (ea[g]),
            .idx_out (idx_out[g]),
            .ea_vld  (ea_vld[g])
        );
    end

endmodule

// File: rtl/dual_dag_chk.sv
module dual_dag_chk #(
    parameter int AW   = 32,
    parameter int NREG = 8,
    parameter int NGEN = 2,
    localparam int SW  = $clog2(NREG),
    localparam int NW  = $clog2(AW + 1)
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NGEN-1:0]         op_en,
    input logic [NGEN-1:0][SW-1:0] op_ireg,
    input logic [NGEN-1:0][1:0]    op_mode,
    input logic [NGEN-1:0][NW-1:0] op_brn,
    input logic [NGEN-1:0]         wr_en,
    input logic [NGEN-1:0][AW-1:0] ea,
    input logic [NGEN-1:0][AW-1:0] idx_out,
    input logic [NGEN-1:0]         ea_vld
);

    // R1: reset clears the result ports
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (ea_vld == '0 && idx_out == '0 && ea == '0));

    for (genvar g = 0; g < NGEN; g++) begin : g_chk
        // R11: valid follows the request by one cycle
        assert_vld_follow_R11: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (ea_vld[g] == $past(op_en[g])));

        // R11: results hold while idle
        assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
            !op_en[g] |=> ($stable(idx_out[g]) && $stable(ea[g])));

        // R2: chained post-modify accesses continue from the reported pointer
        assert_post_chain_R2: assert property (@(posedge clk) disable iff (rst)
            (op_en[g] && !op_mode[g][0] && op_brn[g] == '0 && $past(op_en[g]) &&
             $past(op_ireg[g]) == op_ireg[g] && !$past(wr_en[g]))
            |=> (ea[g] == $past(idx_out[g])));

        // R3: pre-modify leaves the pointer as it was
        assert_pre_keep_R3: assert property (@(posedge clk) disable iff (rst)
            (op_en[g] && op_mode[g][0] && $past(op_en[g]) &&
             $past(op_ireg[g]) == op_ireg[g] && !$past(wr_en[g]))
            |=> (idx_out[g] == $past(idx_out[g])));
    end

endmodule

bind dual_dag dual_dag_chk #(.AW(AW), .NREG(NREG), .NGEN(NGEN)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_en   (op_en),
    .op_ireg (op_ireg),
    .op_mode (op_mode),
    .op_brn  (op_brn),
    .wr_en   (wr_en),
    .ea      (ea),
    .idx_out (idx_out),
    .ea_vld  (ea_vld)
);

// File: tb/sim_dual_dag.sv
`timescale 1ns/1ps
module sim_dual_dag;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        op_en;
    logic [1:0][2:0]   op_ireg, op_mreg;
    logic [1:0][1:0]   op_mode;
    logic [1:0][31:0]  op_imm;
    logic [1:0][5:0]   op_brn;
    logic [1:0]        wr_en;
    logic [1:0][1:0]   wr_kind;
    logic [1:0][2:0]   wr_idx;
    logic [1:0][31:0]  wr_data;
    logic [1:0][31:0]  ea, idx_out;
    logic [1:0]        ea_vld;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dual_dag u0 (
        .clk(clk), .rst(rst), .op_en(op_en), .op_ireg(op_ireg), .op_mreg(op_mreg),
        .op_mode(op_mode), .op_imm(op_imm), .op_brn(op_brn), .wr_en(wr_en),
        .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data), .ea(ea),
        .idx_out(idx_out), .ea_vld(ea_vld)
    );

    // w: write row; code: wr_kind or op_mode; r: wr_idx or op_ireg; m: op_mreg
    typedef struct packed {
        logic [3:0]  req;
        logic        w;
        logic [1:0]  code;
        logic [2:0]  r;
        logic [2:0]  m;
        logic [5:0]  n;
        logic [31:0] d;
        logic [31:0] xe;
        logic [31:0] xi;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VT [NV] = '{
        '{4'd10, 1'b1, 2'd3, 3'd0, 3'd0, 6'd0, 32'd100, 32'd0, 32'd0},          // R10 base0=100
        '{4'd10, 1'b1, 2'd2, 3'd0, 3'd0, 6'd0, 32'd10, 32'd0, 32'd0},           // len0=10
        '{4'd10, 1'b1, 2'd0, 3'd0, 3'd0, 6'd0, 32'd100, 32'd0, 32'd0},          // idx0=100
        '{4'd10, 1'b1, 2'd1, 3'd0, 3'd0, 6'd0, 32'd4, 32'd0, 32'd0},            // step0=4
        '{4'd10, 1'b1, 2'd1, 3'd1, 3'd0, 6'd0, 32'hFFFF_FFFD, 32'd0, 32'd0},    // step1=-3
        '{4'd2,  1'b0, 2'd0, 3'd0, 3'd0, 6'd0, 32'd0, 32'd100, 32'd104},        // R2
        '{4'd2,  1'b0, 2'd0, 3'd0, 3'd0, 6'd0, 32'd0, 32'd104, 32'd108},        // R2
        '{4'd5,  1'b0, 2'd0, 3'd0, 3'd0, 6'd0, 32'd0, 32'd108, 32'd102},        // R5 112 -> 102
        '{4'd6,  1'b0, 2'd0, 3'd0, 3'd1, 6'd0, 32'd0, 32'd102, 32'd109},        // R6 99 -> 109
        '{4'd3,  1'b0, 2'd1, 3'd0, 3'd0, 6'd0, 32'd0, 32'd113, 32'd109},        // R3 no wrap on address
        '{4'd4,  1'b0, 2'd2, 3'd0, 3'd0, 6'd0, 32'd5, 32'd109, 32'd104},        // R4 imm 5, wraps
        '{4'd4,  1'b0, 2'd3, 3'd0, 3'd0, 6'd0, 32'd16, 32'd120, 32'd104},       // R4 pre imm 16
        '{4'd10, 1'b1, 2'd0, 3'd1, 3'd0, 6'd0, 32'h1000, 32'd0, 32'd0},         // idx1
        '{4'd10, 1'b1, 2'd1, 3'd2, 3'd0, 6'd0, 32'h20, 32'd0, 32'd0},           // step2
        '{4'd7,  1'b0, 2'd0, 3'd1, 3'd2, 6'd0, 32'd0, 32'h1000, 32'h1020},      // R7 linear
        '{4'd7,  1'b0, 2'd0, 3'd1, 3'd2, 6'd0, 32'd0, 32'h1020, 32'h1040},      // R7
        '{4'd10, 1'b1, 2'd0, 3'd2, 3'd0, 6'd0, 32'd1, 32'd0, 32'd0},            // idx2=1
        '{4'd10, 1'b1, 2'd1, 3'd3, 3'd0, 6'd0, 32'd1, 32'd0, 32'd0},            // step3=1
        '{4'd8,  1'b0, 2'd0, 3'd2, 3'd3, 6'd3, 32'd0, 32'd4, 32'd2},            // R8 001->100
        '{4'd8,  1'b0, 2'd0, 3'd2, 3'd3, 6'd3, 32'd0, 32'd2, 32'd3},            // R8 010->010
        '{4'd8,  1'b0, 2'd0, 3'd2, 3'd3, 6'd3, 32'd0, 32'd6, 32'd4},            // R8 011->110
        '{4'd8,  1'b0, 2'd0, 3'd2, 3'd3, 6'd4, 32'd0, 32'd2, 32'd5},            // R8 0100->0010
        '{4'd10, 1'b1, 2'd0, 3'd3, 3'd0, 6'd0, 32'hABCD_0003, 32'd0, 32'd0},    // idx3
        '{4'd8,  1'b0, 2'd0, 3'd3, 3'd3, 6'd8, 32'd0, 32'hABCD_00C0, 32'hABCD_0004}, // R8 upper kept
        '{4'd10, 1'b1, 2'd0, 3'd4, 3'd0, 6'd0, 32'd1, 32'd0, 32'd0},            // idx4=1
        '{4'd8,  1'b0, 2'd3, 3'd4, 3'd0, 6'd32, 32'd0, 32'h8000_0000, 32'd1},   // R8 full width
        '{4'd6,  1'b0, 2'd2, 3'd0, 3'd0, 6'd0, 32'hFFFF_FFF6, 32'd104, 32'd104},// R6 step -L
        '{4'd5,  1'b0, 2'd2, 3'd0, 3'd0, 6'd0, 32'd10, 32'd104, 32'd104}        // R5 step +L
    };

    task automatic idle();
        op_en = '0; op_ireg = '0; op_mreg = '0; op_mode = '0; op_imm = '0; op_brn = '0;
        wr_en = '0; wr_kind = '0; wr_idx = '0; wr_data = '0;
    endtask

    task automatic put_op(int g, logic [2:0] r, logic [2:0] m, logic [1:0] md,
                          logic [31:0] imm, logic [5:0] n);
        op_en[g] = 1'b1; op_ireg[g] = r; op_mreg[g] = m; op_mode[g] = md;
        op_imm[g] = imm; op_brn[g] = n;
    endtask

    task automatic put_wr(int g, logic [1:0] k, logic [2:0] r, logic [31:0] d);
        wr_en[g] = 1'b1; wr_kind[g] = k; wr_idx[g] = r; wr_data[g] = d;
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "ea0", ea[0], 32'd0);
        chk("R1", "idx0", idx_out[0], 32'd0);
        chk("R1", "vld", {30'd0, ea_vld}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (VT[i].w) put_wr(0, VT[i].code, VT[i].r, VT[i].d);
            else         put_op(0, VT[i].r, VT[i].m, VT[i].code, VT[i].d, VT[i].n);
            @(negedge clk);
            idle();
            if (!VT[i].w) begin
                chk($sformatf("R%0d", VT[i].req), $sformatf("row%0d ea", i), ea[0], VT[i].xe);
                chk($sformatf("R%0d", VT[i].req), $sformatf("row%0d idx", i), idx_out[0], VT[i].xi);
                chk("R11", $sformatf("row%0d vld", i), {31'd0, ea_vld[0]}, 32'd1);
            end
        end

        // R9: second generator, then both in the same cycle
        put_wr(1, 2'd0, 3'd0, 32'h500); @(negedge clk); idle();
        put_wr(1, 2'd1, 3'd0, 32'd8);   @(negedge clk); idle();
        put_op(0, 3'd0, 3'd0, 2'd0, 32'd0, 6'd0);
        put_op(1, 3'd0, 3'd0, 2'd0, 32'd0, 6'd0);
        @(negedge clk); idle();
        chk("R9", "gen0 ea", ea[0], 32'd104);
        chk("R9", "gen0 idx", idx_out[0], 32'd108);
        chk("R9", "gen1 ea", ea[1], 32'h500);
        chk("R9", "gen1 idx", idx_out[1], 32'h508);

        // R10: write collides with post-modify update of idx1
        put_op(0, 3'd1, 3'd2, 2'd0, 32'd0, 6'd0);
        put_wr(0, 2'd0, 3'd1, 32'h7777);
        @(negedge clk); idle();
        chk("R10", "collide ea", ea[0], 32'h1040);
        put_op(0, 3'd1, 3'd2, 2'd0, 32'd0, 6'd0);
        @(negedge clk); idle();
        chk("R10", "write kept", ea[0], 32'h7777);
        chk("R10", "next idx", idx_out[0], 32'h7797);

        // R11: idle cycle holds results
        @(negedge clk);
        chk("R11", "idle vld", {31'd0, ea_vld[0]}, 32'd0);
        chk("R11", "idle ea", ea[0], 32'h7777);
        chk("R11", "idle idx", idx_out[0], 32'h7797);

        // R1: reset mid-run clears registers
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R1", "post-reset ea1", ea[1], 32'd0);
        chk("R1", "post-reset idx0", idx_out[0], 32'd0);
        put_op(0, 3'd0, 3'd0, 2'd0, 32'd0, 6'd0);
        put_op(1, 3'd0, 3'd0, 2'd0, 32'd0, 6'd0);
        @(negedge clk); idle();
        chk("R1", "cleared gen0 ea", ea[0], 32'd0);
        chk("R1", "cleared gen0 idx", idx_out[0], 32'd0);
        chk("R1", "cleared gen1 ea", ea[1], 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule